// File: doc/BRIEF.md
# Windowed-Reload System Watchdog Timer

This block watches over software from the moment reset is released. A counter climbs toward overflow at a rate set by a selectable prescaler. Software must strobe the service input before the counter wraps. Each service writes a programmed value into the counter's upper byte and clears everything below it, so software picks the length of the next window by choosing that value. If the counter wraps, the block asserts an internal reset request and pulls an active-low reset-out line low. Both stay active for a fixed hold time. The block then restarts itself in its reset state.

Every reset enables supervision. Software may switch the watchdog off, but only until it strobes the end-of-initialization input. That strobe sets a flag that only a reset, or the block's own restart, clears. Once the flag is set, disable requests are ignored, so a fault after start-up cannot silence the watchdog.

Top module: `wdt_supervisor`

## Requirements
- R1: After reset, sys_reset_req_o is 0, reset_out_no is 1, the counter is zero, supervision is enabled and the end-of-initialization flag is clear.
- R2: div_sel_i selects the prescaler ratio: 0 divides the system clock by 2, 1 by 4, 2 by 128 and 3 by 256. The counter advances by one each time a full divided period elapses.
- R3: The counter is CNT_W bits wide and counts up. It overflows when it advances from all-ones. With no service, no disable and div_sel_i = 0, the request rises after exactly 2 * 2^CNT_W system clock edges, counted from reset release.
- R4: A service strobe loads reload_i into the top RELOAD_W counter bits, clears the lower bits and restarts the prescaler phase. The next overflow comes exactly (2^CNT_W - reload_i * 2^(CNT_W-RELOAD_W)) * divisor edges after the service edge. Repeated service prevents overflow.
- R5: A disable_i strobe taken before the end-of-initialization flag is set stops the counter until the next reset, and no overflow occurs. A later init_done_i strobe does not turn supervision back on.
- R6: Once init_done_i has been seen, disable_i has no effect. The flag is sticky, and a second init_done_i strobe changes nothing. When disable_i and init_done_i arrive in the same cycle, the disable is honoured.
- R7: At the overflow edge, sys_reset_req_o goes to 1 and reset_out_no goes to 0. While they are active the counter does not advance.
- R8: Both reset outputs stay active for exactly HOLD_CLKS system clocks and are then released. At release the block returns to its reset state: counter zero, supervision enabled, flag clear, and a fresh default interval starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| div_sel_i | input | 2 | Prescaler ratio select |
| reload_i | input | RELOAD_W | Upper-counter value written on service |
| service_i | input | 1 | Service strobe, one clock wide |
| disable_i | input | 1 | Disable request strobe |
| init_done_i | input | 1 | End-of-initialization strobe |
| sys_reset_req_o | output | 1 | Internal hardware reset request, active high |
| reset_out_no | output | 1 | External reset-out, active low |

## Verification
The bench builds the block with CNT_W = 10, RELOAD_W = 4 and HOLD_CLKS = 5. The smaller counter brings the default interval down to 2048 clocks, and the divide-by-128 and divide-by-256 windows down to 16384 clocks. Every interval can therefore be measured to the exact clock edge, including the restart that follows a hold. A hold of 5 rather than 4 shows that the hold length follows the parameter. The reload arithmetic, the lower-bit clear and the all-ones boundary take the same form at this width as at 16 bits.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    PSC_DIV2   = 2'd0,
    PSC_DIV4   = 2'd1,
    PSC_DIV128 = 2'd2,
    PSC_DIV256 = 2'd3
  } psc_sel_e;

  localparam int unsigned PSC_MAX_DIV = 256;

  // Ratio of system clocks per counter step for a select code.
  function automatic int unsigned psc_divisor(input logic [1:0] sel);
    case (psc_sel_e'(sel))
      PSC_DIV2:   return 2;
      PSC_DIV4:   return 4;
      PSC_DIV128: return 128;
      default:    return 256;
    endcase
  endfunction

endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler
  import wdt_pkg::*;
#(
  parameter int unsigned PSC_W = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clear_i,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);

  logic [PSC_W-1:0] phase_q;
  logic [PSC_W-1:0] terminal;

  // Last phase value before a step is due.
  assign terminal = PSC_W'(psc_divisor(sel_i) - 1);
  assign tick_o   = run_i && (phase_q == terminal);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= '0;
    end else if (clear_i) begin
      phase_q <= '0;
    end else if (run_i) begin
      phase_q <= tick_o ? '0 : phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned RELOAD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clear_i,
  input  logic                load_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                tick_i,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                ovf_o
);

  localparam int unsigned LOW_W = CNT_W - RELOAD_W;

  // Counter image written by a service: reload in the top bits, zeros below.
  function automatic logic [CNT_W-1:0] reload_image(input logic [RELOAD_W-1:0] r);
    return {r, {LOW_W{1'b0}}};
  endfunction

  logic [CNT_W-1:0] cnt_q;

  assign cnt_o = cnt_q;
  assign ovf_o = tick_i && (&cnt_q) && !load_i && !clear_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= reload_image(reload_i);
    end else if (tick_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/wdt_ctrl.sv
module wdt_ctrl #(
  parameter int unsigned HOLD_CLKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic disable_i,
  input  logic eoi_i,
  input  logic ovf_i,
  output logic en_o,
  output logic init_done_o,
  output logic trip_o,
  output logic restart_o
);

  localparam int unsigned HOLD_W = $clog2(HOLD_CLKS + 1);

  logic              en_q;
  logic              init_q;
  logic              trip_q;
  logic [HOLD_W-1:0] hold_q;

  assign restart_o   = trip_q && (hold_q == HOLD_W'(HOLD_CLKS - 1));
  assign en_o        = en_q;
  assign init_done_o = init_q;
  assign trip_o      = trip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b1;
    end else if (restart_o) begin
      en_q <= 1'b1;
    end else if (disable_i && !init_q) begin
      en_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      init_q <= 1'b0;
    end else if (restart_o) begin
      init_q <= 1'b0;
    end else if (eoi_i) begin
      init_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trip_q <= 1'b0;
      hold_q <= '0;
    end else if (restart_o) begin
      trip_q <= 1'b0;
      hold_q <= '0;
    end else if (trip_q) begin
      hold_q <= hold_q + 1'b1;
    end else if (ovf_i) begin
      trip_q <= 1'b1;
      hold_q <= '0;
    end
  end

endmodule

// File: rtl/wdt_supervisor.sv
module wdt_supervisor
  import wdt_pkg::*;
#(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RELOAD_W  = 8,
  parameter int unsigned HOLD_CLKS = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          div_sel_i,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                service_i,
  input  logic                disable_i,
  input  logic                init_done_i,
  output logic                sys_reset_req_o,
  output logic                reset_out_no
);

  localparam int unsigned PSC_W = $clog2(PSC_MAX_DIV);

  // Named internal events, visible to the bound checker.
  logic             tick;
  logic             ovf_evt;
  logic             wdt_en;
  logic             init_done;
  logic             trip;
  logic             restart;
  logic             run;
  logic [CNT_W-1:0] cnt;

  assign run = wdt_en && !trip;

  wdt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (service_i || restart),
    .run_i   (run),
    .sel_i   (div_sel_i),
    .tick_o  (tick)
  );

  wdt_counter #(.CNT_W(CNT_W), .RELOAD_W(RELOAD_W)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (restart),
    .load_i   (service_i),
    .reload_i (reload_i),
    .tick_i   (tick),
    .cnt_o    (cnt),
    .ovf_o    (ovf_evt)
  );

  wdt_ctrl #(.HOLD_CLKS(HOLD_CLKS)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .disable_i   (disable_i),
    .eoi_i       (init_done_i),
    .ovf_i       (ovf_evt),
    .en_o        (wdt_en),
    .init_done_o (init_done),
    .trip_o      (trip),
    .restart_o   (restart)
  );

  assign sys_reset_req_o = trip;
  assign reset_out_no    = ~trip;

endmodule

// File: rtl/wdt_supervisor_chk.sv
module wdt_supervisor_chk #(
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned RELOAD_W  = 8,
  parameter int unsigned HOLD_CLKS = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [RELOAD_W-1:0] reload_i,
  input logic                service_i,
  input logic                sys_reset_req_o,
  input logic                reset_out_no,
  input logic                tick,
  input logic                ovf_evt,
  input logic                wdt_en,
  input logic                init_done,
  input logic                restart,
  input logic [CNT_W-1:0]    cnt
);

  localparam int unsigned LOW_W = CNT_W - RELOAD_W;

  int unsigned hold_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hold_seen <= 0;
    else         hold_seen <= sys_reset_req_o ? hold_seen + 1 : 0;
  end

  AST_SERVICE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    service_i && !restart |=> cnt == {$past(reload_i), {LOW_W{1'b0}}}); // R4
  AST_TICK_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && !service_i && !restart && !(&cnt) |=> cnt == $past(cnt) + 1'b1); // R3
  AST_DISABLED_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wdt_en |-> !tick && !ovf_evt); // R5
  AST_EN_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done && wdt_en |=> wdt_en); // R6
  AST_INIT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_done && !restart |=> init_done); // R6
  AST_OVF_TRIPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt |=> sys_reset_req_o && !reset_out_no); // R7
  AST_HOLD_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sys_reset_req_o |-> !tick); // R7
  AST_HOLD_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_reset_req_o) |-> hold_seen == HOLD_CLKS); // R8
  AST_RESTART_STATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sys_reset_req_o) |-> cnt == '0 && wdt_en && !init_done); // R8

endmodule

bind wdt_supervisor wdt_supervisor_chk #(
  .CNT_W(CNT_W), .RELOAD_W(RELOAD_W), .HOLD_CLKS(HOLD_CLKS)
) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .reload_i        (reload_i),
  .service_i       (service_i),
  .sys_reset_req_o (sys_reset_req_o),
  .reset_out_no    (reset_out_no),
  .tick            (tick),
  .ovf_evt         (ovf_evt),
  .wdt_en          (wdt_en),
  .init_done       (init_done),
  .restart         (restart),
  .cnt             (cnt)
);

// File: tb/wdt_supervisor_tb.sv
module wdt_supervisor_tb;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int CW   = 10;
  localparam int RW   = 4;
  localparam int HOLD = 5;
  localparam int DEF  = 2 * (1 << CW);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [1:0]    div_sel = 2'd0;
  logic [RW-1:0] reload = '0;
  logic          service = 1'b0;
  logic          dis = 1'b0;
  logic          eoi = 1'b0;
  logic          req;
  logic          rout_n;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_supervisor #(.CNT_W(CW), .RELOAD_W(RW), .HOLD_CLKS(HOLD)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .div_sel_i(div_sel), .reload_i(reload),
    .service_i(service), .disable_i(dis), .init_done_i(eoi),
    .sys_reset_req_o(req), .reset_out_no(rout_n)
  );

  function automatic int div_of(input int sel);
    if (sel == 0) return 2;
    if (sel == 1) return 4;
    if (sel == 2) return 128;
    return 256;
  endfunction

  function automatic int interval(input int r, input int sel);
    return ((1 << CW) - r * (1 << (CW - RW))) * div_of(sel);
  endfunction

  task automatic check(input bit ok, input string rq, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  endtask

  task automatic do_reset(output int start);
    @(negedge clk);
    rst_ni = 1'b0; service = 0; dis = 0; eoi = 0; div_sel = 0; reload = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    start = cyc;
  endtask

  task automatic pulse_service(input int sel, input int r, output int start);
    @(negedge clk);
    div_sel = 2'(sel); reload = RW'(r); service = 1'b1;
    @(negedge clk);
    service = 1'b0;
    start = cyc;
  endtask

  task automatic pulse(input bit d, input bit e);
    @(negedge clk);
    dis = d; eoi = e;
    @(negedge clk);
    dis = 1'b0; eoi = 1'b0;
  endtask

  task automatic wait_trip(input int start, input int limit, output int n);
    while (!req && (cyc - start) < limit) @(negedge clk);
    n = cyc - start;
  endtask

  task automatic hold_len(output int h);
    h = 0;
    while (req) begin
      h++;
      @(negedge clk);
    end
  endtask

  task automatic quiet_for(input int cycles, output bit seen);
    seen = 0;
    repeat (cycles) begin
      @(negedge clk);
      if (req || !rout_n) seen = 1;
    end
  endtask

  task automatic t_reset_default();
    int s, n, h;
    do_reset(s);
    check(req == 0, "R1 reset req", req, 0);
    check(rout_n == 1, "R1 reset out_n", rout_n, 1);
    wait_trip(s, DEF + 10, n);
    check(n == DEF, "R3 default interval", n, DEF);
    check(rout_n == 0, "R7 reset_out low on trip", rout_n, 0);
    hold_len(h);
    check(h == HOLD, "R8 hold length", h, HOLD);
    s = cyc;
    wait_trip(s, DEF + 10, n);
    check(n == DEF, "R8 interval after restart", n, DEF);
  endtask

  task automatic t_service(input int sel, input int r, input string rq);
    int s, n, e;
    do_reset(s);
    pulse_service(sel, r, s);
    e = interval(r, sel);
    wait_trip(s, e + 10, n);
    check(n == e, rq, n, e);
  endtask

  task automatic t_keepalive();
    int s, n;
    bit seen;
    do_reset(s);
    for (int i = 0; i < 5; i++) begin
      quiet_for(1500, seen);
      check(!seen, "R4 service keeps alive", seen, 0);
      pulse_service(0, 0, s);
    end
    wait_trip(s, DEF + 10, n);
    check(n == DEF, "R4 interval from last service", n, DEF);
  endtask

  task automatic t_disable_early();
    int s;
    bit seen;
    do_reset(s);
    pulse(1, 0);
    quiet_for(3 * DEF, seen);
    check(!seen, "R5 disable before init", seen, 0);
    pulse(0, 1);
    quiet_for(2 * DEF, seen);
    check(!seen, "R5 init does not re-enable", seen, 0);
  endtask

  task automatic t_disable_late();
    int s, n;
    do_reset(s);
    pulse(0, 1);
    pulse(1, 0);
    pulse(0, 1);
    pulse(1, 0);
    wait_trip(s, DEF + 10, n);
    check(n == DEF, "R6 disable ignored after init", n, DEF);
  endtask

  task automatic t_same_cycle();
    int s;
    bit seen;
    do_reset(s);
    pulse(1, 1);
    quiet_for(3 * DEF, seen);
    check(!seen, "R6 same-cycle disable honoured", seen, 0);
  endtask

  task automatic t_restart_clears_init();
    int s, n, h;
    bit seen;
    do_reset(s);
    pulse(0, 1);
    wait_trip(s, DEF + 10, n);
    check(n == DEF, "R6 trip with init set", n, DEF);
    hold_len(h);
    check(h == HOLD, "R8 hold length second", h, HOLD);
    check(rout_n == 1, "R8 reset_out released", rout_n, 1);
    pulse(1, 0);
    quiet_for(3 * DEF, seen);
    check(!seen, "R8 restart clears init flag", seen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    finish_run();
  end

  initial begin
    t_reset_default();
    t_service(1, 10, "R4 div4 reload 10");
    t_service(2, 14, "R2 div128 reload 14");
    t_service(3, 15, "R2 div256 reload 15");
    t_service(0, 15, "R4 div2 reload max");
    t_service(1, 0, "R2 div4 reload 0");
    t_keepalive();
    t_disable_early();
    t_disable_late();
    t_same_cycle();
    t_restart_clears_init();
    finish_run();
  end

endmodule